// File: doc/BRIEF.md
# Master Clock Loss Monitor with Recovery Reset

This block watches a master reference clock and reports when it has stopped toggling usefully. All of its logic runs on an independent free-running monitor clock. The master clock is treated as a data signal: it is synchronized and sampled once per monitor cycle. The samples are grouped into fixed windows of one microsecond each. A window counts as weak when fewer than 30 % of its samples are high. Ten weak windows in a row, which is ten microseconds, raise the clock-lost flag. While that flag is up, the chip's line drivers are expected to float.

Once the master clock is lost, the block waits for a healthy window. It then drops the flag and issues a short internal reset of fixed length, always shorter than two microseconds. The external active-low reset pin and this automatic reset are merged into one internal reset. That internal reset is synchronous to the monitor clock.

Separately, the block decodes a 4-bit frequency select into the base rate and the multiplier of the master clock. Timing logic elsewhere in the chip uses these values.

Top module: `mclk_watchdog`

## Requirements
- R1: `rate_2m048` equals `freq_sel[3]` (0 selects the 1.544 MHz base, 1 selects the 2.048 MHz base). `rate_mult` equals `freq_sel[2:0]` plus one, a value from 1 to 8. Both outputs are registered and follow a select change one monitor cycle later.
- R2: A window of `WIN_CYCLES` samples (default 8, one microsecond) is weak when its high-sample count, multiplied by 100, is less than `DUTY_PCT` (default 30) times `WIN_CYCLES`. With the defaults this means at most 2 high samples. A steady 25 % duty clock therefore leads to loss, and a steady 37.5 % duty clock never does.
- R3: `clk_lost` rises after `LOSS_WINDOWS` (default 10) consecutive weak windows. A dropout of 8 µs or less never raises it. A dropout of 16 µs always does.
- R4: Any window that is not weak, seen before the count completes, restarts the weak-window count from zero.
- R5: While `clk_lost` is high, `int_rst_n` stays high. No reset is issued until the clock returns.
- R6: While lost, `RECOV_WINDOWS` (default 1) consecutive healthy windows clear `clk_lost`. On the cycle after it clears, `int_rst_n` goes low for exactly `RST_CYCLES` (default 12) monitor cycles.
- R7: A dropout too short to raise `clk_lost` produces no internal reset pulse.
- R8: Holding `ext_rst_n` low for N monitor cycles drives `int_rst_n` low for N cycles, starting three cycles later. This reset also returns `clk_lost` to 0, and no automatic pulse follows it.
- R9: While the external reset is held, `clk_lost` is 0 and `int_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock; all logic runs on it |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| ref_clk | input | 1 | Master clock under observation, sampled as data |
| freq_sel | input | 4 | Master clock frequency select |
| clk_lost | output | 1 | Master clock missing; also the line-driver float request |
| rate_2m048 | output | 1 | Decoded base rate: 0 = 1.544 MHz, 1 = 2.048 MHz |
| rate_mult | output | 4 | Decoded multiplier, 1 to 8 |
| int_rst_n | output | 1 | Internal reset, active low, combining the pin and the automatic pulse |

## Verification
The master clock is driven with five kinds of pattern:
- A 50 % square wave, as the healthy baseline.
- Full dropouts of 5 µs and 8 µs, which must stay below the loss threshold.
- A 16 µs dropout, which must trip the flag and, once the clock returns, produce exactly one 12-cycle reset.
- Steady 25 % and 37.5 % duty waves, which fall on either side of the 30 % threshold and show that duty, not just toggling, is judged.

An external reset applied during a loss shows that the pin pulse passes straight through, with its length kept, and that it cancels the pending automatic reset. All sixteen select codes are swept to cover the decode.

// File: rtl/mclk_pkg.sv
// Package: shared types and the frequency-select decode for the master clock monitor.
// Assumes a 4-bit select: the top bit picks the base rate, the lower three bits give the multiplier minus one.
package mclk_pkg;

    localparam int MULT_W = 4;

    // Monitor states: clock healthy, clock missing, recovery reset in progress.
    typedef enum logic [1:0] {
        MON_OK    = 2'd0,
        MON_LOST  = 2'd1,
        MON_RESET = 2'd2
    } mon_state_t;

    // Decoded master clock rate.
    typedef struct packed {
        logic              base_2m048;
        logic [MULT_W-1:0] mult;
    } rate_t;

    // Turn a select code into base rate and multiplier.
    function automatic rate_t decode_rate(input logic [3:0] sel);
        rate_t r;
        r.base_2m048 = sel[3];
        r.mult       = {1'b0, sel[2:0]} + MULT_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/mclk_sync.sv
// Module: multi-stage synchronizer for a vector of independent single-bit signals.
// Assumes each bit is a level and is not related to the other bits; there is no reset, so the stages flush within STAGES cycles.
module mclk_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        stage_q[0] <= d;
    end

    // Later stages form the rest of the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mclk_duty_window.sv
// Module: counts high samples of the synchronized master clock over fixed back-to-back windows.
// At the end of each window it pulses win_done for one cycle and flags win_low when the high
// share is below DUTY_PCT percent. Assumes the monitor clock oversamples the master clock.
module mclk_duty_window #(
    parameter int WIN_CYCLES = 8,
    parameter int DUTY_PCT   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic win_done,
    output logic win_low
);

    localparam int CW       = $clog2(WIN_CYCLES + 1);
    localparam int MIN_HIGH = (DUTY_PCT * WIN_CYCLES + 99) / 100;
    localparam logic [CW-1:0] LAST_POS = CW'(WIN_CYCLES - 1);
    localparam logic [CW-1:0] MIN_H    = CW'(MIN_HIGH);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] high_q;
    logic [CW-1:0] high_total;

    // High count including the current sample.
    assign high_total = high_q + CW'(sample);

    // Advance the window position, accumulate high samples and judge each window at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            high_q   <= '0;
            win_done <= 1'b0;
            win_low  <= 1'b0;
        end else begin
            win_done <= (pos_q == LAST_POS);
            if (pos_q == LAST_POS) begin
                win_low <= (high_total < MIN_H);
                pos_q   <= '0;
                high_q  <= '0;
            end else begin
                pos_q  <= pos_q + 1'b1;
                high_q <= high_total;
            end
        end
    end

endmodule

// File: rtl/mclk_loss_fsm.sv
// Module: turns the stream of window verdicts into the lost flag and the recovery reset pulse.
// Assumes win_done pulses once per window with win_low valid in the same cycle.
module mclk_loss_fsm
    import mclk_pkg::*;
#(
    parameter int LOSS_WINDOWS  = 10,
    parameter int RECOV_WINDOWS = 1,
    parameter int RST_CYCLES    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_done,
    input  logic win_low,
    output logic clk_lost,
    output logic auto_rst
);

    localparam int BW = $clog2(LOSS_WINDOWS + 1);
    localparam int GW = $clog2(RECOV_WINDOWS + 1);
    localparam int PW = $clog2(RST_CYCLES + 1);

    mon_state_t    state_q;
    logic [BW-1:0] bad_q;
    logic [GW-1:0] good_q;
    logic [PW-1:0] pulse_q;

    // Count runs of weak or healthy windows and time the recovery reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_OK;
            bad_q   <= '0;
            good_q  <= '0;
            pulse_q <= '0;
        end else begin
            case (state_q)
                MON_OK: begin
                    if (win_done) begin
                        if (!win_low) begin
                            bad_q <= '0;
                        end else if (bad_q == BW'(LOSS_WINDOWS - 1)) begin
                            bad_q   <= '0;
                            good_q  <= '0;
                            state_q <= MON_LOST;
                        end else begin
                            bad_q <= bad_q + 1'b1;
                        end
                    end
                end
                MON_LOST: begin
                    if (win_done) begin
                        if (win_low) begin
                            good_q <= '0;
                        end else if (good_q == GW'(RECOV_WINDOWS - 1)) begin
                            good_q  <= '0;
                            pulse_q <= '0;
                            state_q <= MON_RESET;
                        end else begin
                            good_q <= good_q + 1'b1;
                        end
                    end
                end
                MON_RESET: begin
                    if (pulse_q == PW'(RST_CYCLES - 1)) begin
                        pulse_q <= '0;
                        state_q <= MON_OK;
                    end else begin
                        pulse_q <= pulse_q + 1'b1;
                    end
                end
                default: state_q <= MON_OK;
            endcase
        end
    end

    // Flags derived from the state.
    assign clk_lost = (state_q == MON_LOST);
    assign auto_rst = (state_q == MON_RESET);

endmodule

// File: rtl/mclk_rate_decode.sv
// Module: registers the decoded base rate and multiplier of the master clock.
// Assumes the select is static or changes slowly; the outputs follow it one cycle later.
module mclk_rate_decode
    import mclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  sel,
    output logic        base_2m048,
    output logic [MULT_W-1:0] mult
);

    rate_t rate_q;

    // Capture the decode each cycle; reset to the slowest rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q.base_2m048 <= 1'b0;
            rate_q.mult       <= MULT_W'(1);
        end else begin
            rate_q <= decode_rate(sel);
        end
    end

    assign base_2m048 = rate_q.base_2m048;
    assign mult       = rate_q.mult;

endmodule

// File: rtl/mclk_watchdog.sv
// Module: top of the master clock monitor. Synchronizes the master clock and the reset pin to
// the monitor clock, judges the duty cycle per window, flags loss, issues the recovery reset
// and decodes the frequency select. Assumes mon_clk is free running and at least twice as fast as ref_clk.
module mclk_watchdog
    import mclk_pkg::*;
#(
    parameter int WIN_CYCLES    = 8,
    parameter int DUTY_PCT      = 30,
    parameter int LOSS_WINDOWS  = 10,
    parameter int RECOV_WINDOWS = 1,
    parameter int RST_CYCLES    = 12,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              mon_clk,
    input  logic              ext_rst_n,
    input  logic              ref_clk,
    input  logic [3:0]        freq_sel,
    output logic              clk_lost,
    output logic              rate_2m048,
    output logic [MULT_W-1:0] rate_mult,
    output logic              int_rst_n
);

    logic [1:0] sync_q;
    logic       sys_rst_n;
    logic       ref_s;
    logic       win_done;
    logic       win_low;
    logic       auto_rst;
    logic       int_rst_q;

    // Bring the pin and the master clock into the monitor domain.
    mclk_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (mon_clk),
        .d   ({ext_rst_n, ref_clk}),
        .q   (sync_q)
    );

    assign sys_rst_n = sync_q[1];
    assign ref_s     = sync_q[0];

    mclk_duty_window #(.WIN_CYCLES(WIN_CYCLES), .DUTY_PCT(DUTY_PCT)) u_win (
        .clk      (mon_clk),
        .rst_n    (sys_rst_n),
        .sample   (ref_s),
        .win_done (win_done),
        .win_low  (win_low)
    );

    mclk_loss_fsm #(
        .LOSS_WINDOWS  (LOSS_WINDOWS),
        .RECOV_WINDOWS (RECOV_WINDOWS),
        .RST_CYCLES    (RST_CYCLES)
    ) u_fsm (
        .clk      (mon_clk),
        .rst_n    (sys_rst_n),
        .win_done (win_done),
        .win_low  (win_low),
        .clk_lost (clk_lost),
        .auto_rst (auto_rst)
    );

    mclk_rate_decode u_dec (
        .clk        (mon_clk),
        .rst_n      (sys_rst_n),
        .sel        (freq_sel),
        .base_2m048 (rate_2m048),
        .mult       (rate_mult)
    );

    // Merge the pin reset and the recovery pulse into one registered internal reset.
    always_ff @(posedge mon_clk) begin
        if (!sys_rst_n) begin
            int_rst_q <= 1'b0;
        end else begin
            int_rst_q <= ~auto_rst;
        end
    end

    assign int_rst_n = int_rst_q;

endmodule

// File: rtl/mclk_watchdog_chk.sv
// Module: assertion checker for mclk_watchdog, bound to every instance below.
// Assumes sys_rst_n is the synchronized pin reset inside the top.
module mclk_watchdog_chk #(
    parameter int RST_CYCLES = 12
) (
    input logic       mon_clk,
    input logic       sys_rst_n,
    input logic [3:0] freq_sel,
    input logic       clk_lost,
    input logic       rate_2m048,
    input logic [3:0] rate_mult,
    input logic       int_rst_n
);

    logic [15:0] low_run_q;

    // Length of the current run of internal reset outside the pin reset.
    always_ff @(posedge mon_clk) begin
        if (!sys_rst_n) begin
            low_run_q <= '0;
        end else if (!int_rst_n) begin
            low_run_q <= low_run_q + 1'b1;
        end else begin
            low_run_q <= '0;
        end
    end

    // R1: decode follows the select one cycle later
    p_decode_follows_r1: assert property (@(posedge mon_clk) disable iff (!sys_rst_n)
        $past(sys_rst_n) |-> (rate_mult == ({1'b0, $past(freq_sel[2:0])} + 4'd1))
                             && (rate_2m048 == $past(freq_sel[3])));

    // R1: multiplier stays in 1..8
    p_mult_range_r1: assert property (@(posedge mon_clk) disable iff (!sys_rst_n)
        (rate_mult >= 4'd1) && (rate_mult <= 4'd8));

    // R5: no internal reset while the clock is lost
    p_no_rst_while_lost_r5: assert property (@(posedge mon_clk) disable iff (!sys_rst_n)
        (clk_lost && $past(sys_rst_n)) |-> int_rst_n);

    // R6: recovery starts the internal reset on the next cycle
    p_pulse_after_recover_r6: assert property (@(posedge mon_clk) disable iff (!sys_rst_n)
        ($fell(clk_lost) && $past(sys_rst_n)) |=> !int_rst_n);

    // R6: the recovery pulse never exceeds its length
    p_pulse_len_r6: assert property (@(posedge mon_clk) disable iff (!sys_rst_n)
        low_run_q <= 16'(RST_CYCLES));

endmodule

bind mclk_watchdog mclk_watchdog_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .mon_clk    (mon_clk),
    .sys_rst_n  (sys_rst_n),
    .freq_sel   (freq_sel),
    .clk_lost   (clk_lost),
    .rate_2m048 (rate_2m048),
    .rate_mult  (rate_mult),
    .int_rst_n  (int_rst_n)
);

// File: tb/sim_mclk_watchdog.sv
// Directed bench for mclk_watchdog: one task per scenario, each checking its own results.
module sim_mclk_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 8;    // monitor cycles per microsecond window
    localparam int PULSE      = 12;   // expected recovery pulse length

    logic       mon_clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic [3:0] freq_sel = 4'd0;
    logic       clk_lost;
    logic       rate_2m048;
    logic [3:0] rate_mult;
    logic       int_rst_n;

    int n_tests = 0;
    int n_fail  = 0;

    // Master clock pattern controls.
    int pat_period = 4;
    int pat_high   = 2;
    bit pat_on     = 1'b1;
    int phase      = 0;

    mclk_watchdog u0 (
        .mon_clk    (mon_clk),
        .ext_rst_n  (ext_rst_n),
        .ref_clk    (ref_clk),
        .freq_sel   (freq_sel),
        .clk_lost   (clk_lost),
        .rate_2m048 (rate_2m048),
        .rate_mult  (rate_mult),
        .int_rst_n  (int_rst_n)
    );

    always #(CLK_PERIOD/2) mon_clk = ~mon_clk;

    // Generate the master clock pattern on the falling monitor edge.
    always @(negedge mon_clk) begin
        phase   <= (phase + 1 >= pat_period) ? 0 : phase + 1;
        ref_clk <= pat_on && (phase < pat_high);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Observe n cycles: count internal reset lows, note whether lost was seen, report final lost.
    task automatic watch(input int n, output int lows, output int lost_seen, output int lost_end);
        lows = 0;
        lost_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge mon_clk);
            #1;
            if (!int_rst_n) lows++;
            if (clk_lost) lost_seen = 1;
        end
        lost_end = int'(clk_lost);
    endtask

    task automatic t_reset_state();
        repeat (6) @(negedge mon_clk);
        #1;
        chk("R9 lost during reset", int'(clk_lost), 0);
        chk("R9 int_rst_n during reset", int'(int_rst_n), 0);
        ext_rst_n = 1'b1;
        repeat (6) @(negedge mon_clk);
        #1;
        chk("R9 int_rst_n released", int'(int_rst_n), 1);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 16; c++) begin
            @(negedge mon_clk);
            freq_sel = 4'(c);
            repeat (2) @(negedge mon_clk);
            #1;
            chk("R1 base rate", int'(rate_2m048), c / 8);
            chk("R1 multiplier", int'(rate_mult), (c % 8) + 1);
        end
    endtask

    task automatic t_short_dropout(input int us);
        int l1, s1, e1, l2, s2, e2;
        pat_on = 1'b0;
        watch(us * WIN, l1, s1, e1);
        pat_on = 1'b1;
        watch(6 * WIN, l2, s2, e2);
        chk("R3 short dropout no loss", s1 | s2, 0);
        chk("R7 short dropout no reset", l1 + l2, 0);
    endtask

    task automatic t_long_dropout();
        int l1, s1, e1, l2, s2, e2;
        pat_on = 1'b0;
        watch(20 * WIN, l1, s1, e1);
        chk("R3 long dropout sets lost", e1, 1);
        chk("R5 no reset while lost", l1, 0);
        pat_on = 1'b1;
        watch(60, l2, s2, e2);
        chk("R6 lost cleared on recovery", e2, 0);
        chk("R6 recovery pulse length", l2, PULSE);
    endtask

    task automatic t_duty();
        int l, s, e;
        pat_period = 4; pat_high = 1;        // 25 %: 2 highs per window
        watch(20 * WIN, l, s, e);
        chk("R2 25% duty flagged lost", e, 1);
        pat_period = 4; pat_high = 2;
        watch(60, l, s, e);
        chk("R6 pulse after duty loss", l, PULSE);
        pat_period = 8; pat_high = 3;        // 37.5 %: 3 highs per window
        watch(20 * WIN, l, s, e);
        chk("R2 37.5% duty not lost", s, 0);
        chk("R4 healthy windows keep reset high", l, 0);
        pat_period = 4; pat_high = 2;
        watch(2 * WIN, l, s, e);
    endtask

    task automatic t_ext_reset();
        int l, s, e, la, lb;
        pat_on = 1'b0;
        watch(20 * WIN, l, s, e);
        chk("R8 setup lost", e, 1);
        @(negedge mon_clk);
        ext_rst_n = 1'b0;
        watch(5, la, s, e);
        ext_rst_n = 1'b1;
        watch(12, lb, s, e);
        chk("R8 pin pulse length", la + lb, 5);
        chk("R8 lost cleared by pin", e, 0);
        pat_on = 1'b1;
        watch(60, l, s, e);
        chk("R8 no auto pulse after pin reset", l, 0);
    endtask

    initial begin
        t_reset_state();
        t_decode();
        t_short_dropout(5);
        t_short_dropout(8);
        t_long_dropout();
        t_duty();
        t_ext_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule